// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital control half of an 8-bit successive-approximation analog-to-digital converter that reads one of eight inputs. A 3-bit channel address is captured when the address strobe goes high, and the block drives a one-hot selector for the analog input switches. A start input controls the conversion through both of its edges. The rising edge clears the approximation register and the falling edge starts a new conversion. The block then presents a trial code to an external resistor ladder and reads back a single comparator bit, which settles one result bit per trial, most significant bit first.

When the last trial is resolved, the result goes into an output data register. An end-of-conversion flag rises one clock later. The flag can be wired back to the start input so that conversions run back to back. The data outputs and their per-bit drive enables are for a tri-state pad ring. They carry the register only while output-enable is high. The previous result can be read during the whole of a new conversion.

Top module: `sar_ctrl_top`

## Requirements
- R1: A conversion makes exactly 8 trials, MSB first. `cmp_i` high means the selected input is at or above the trial level, and the trial bit is then kept; otherwise it is cleared. With an ideal comparator the final code equals the input level (0x00 and 0xFF included).
- R2: Each trial lasts 8 clocks. With launch edge L, `trial_o` after edge L+8k+j (k in 0..7, j in 0..7) shows the resolved upper bits, then a 1 at bit 7-k, then zeros. The comparator is sampled at edges L+8k+8.
- R3: The clock edge that first sees `start_i` high after it was low clears `trial_o` to 0 and drives `eoc_o` low.
- R4: The clock edge that first sees `start_i` low after it was high is the launch edge L; `trial_o` reads 0x80 right after it.
- R5: A start rising edge during a conversion aborts it. No result is stored and no flag is raised. The next falling edge starts a fresh 8-trial conversion.
- R6: The output data register takes the result at edge L+64, and `eoc_o` rises at edge L+65. `trial_o` returns to 0 at L+64.
- R7: While `eoc_o` is low, including during an aborted conversion, the output data register keeps the previous result.
- R8: The edge that first sees `ale_i` high after it was low captures `addr_i`. Address value N (bit 2 most significant) drives `ch_sel_o` bit N alone. Address changes at any other time have no effect.
- R9: With `oe_i` high, `dout_o` equals the data register and `dout_oe_o` is all ones. With `oe_i` low, both are all zeros.
- R10: After reset, `eoc_o`=0, `trial_o`=0, the data register is 0, and `ch_sel_o`=0x01 (channel 0).
- R11: With `eoc_o` fed back to `start_i`, one external start pulse after reset gives continuous conversions, one every 67 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch strobe, captured on its rising edge |
| addr_i | input | 3 | Channel address |
| start_i | input | 1 | Start: rise clears, fall launches |
| cmp_i | input | 1 | Comparator result, 1 = input at or above trial |
| oe_i | input | 1 | Output enable for the data pads |
| ch_sel_o | output | 8 | One-hot analog channel select |
| trial_o | output | 8 | Trial code to the ladder |
| eoc_o | output | 1 | End of conversion |
| dout_o | output | 8 | Data pad value, zero when disabled |
| dout_oe_o | output | 8 | Per-bit pad drive enable |

## Verification
A corrupted trial register or bit index appears on `trial_o` within one clock, because the ladder code is compared with a reference on every cycle. A wrong comparator decision changes the next trial code eight clocks later and the final data value about sixty clocks later. Timing errors in the trial counter change the clock on which the flag rises, and a clock-by-clock comparison of `eoc_o` catches this on the first conversion. Latch errors show at once on `ch_sel_o`, and errors in data-register retention show on `dout_o` for as long as a conversion is running.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CONV  = 2'd2,
    ST_FIN   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/sar_chan_latch.sv
module sar_chan_latch #(
  parameter int CH_W = 3,
  localparam int N_CH = 1 << CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic [CH_W-1:0] addr_i,
  output logic [N_CH-1:0] sel_o
);
  logic            strobe_q;
  logic [CH_W-1:0] chan_q;
  logic [CH_W-1:0] chan_n;
  logic            cap_en;

  assign cap_en = strobe_i & ~strobe_q;

  always_comb begin
    chan_n = chan_q;
    if (cap_en) chan_n = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      chan_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      chan_q   <= chan_n;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign sel_o[g] = (chan_q == CH_W'(g));
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_rise_i,
  input  logic              go_fall_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] trial_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              eoc_o
);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] MSB_ONE  = DATA_W'(1) << (DATA_W - 1);

  sar_state_e        state_q, state_n;
  logic [DATA_W-1:0] sar_q, sar_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              eoc_q, eoc_n;
  logic [DATA_W-1:0] bit_mask;
  logic [DATA_W-1:0] next_mask;
  logic [DATA_W-1:0] decided;

  assign bit_mask  = DATA_W'(1) << idx_q;
  assign next_mask = bit_mask >> 1;
  assign decided   = cmp_i ? sar_q : (sar_q & ~bit_mask);

  always_comb begin
    state_n    = state_q;
    sar_n      = sar_q;
    idx_n      = idx_q;
    cnt_n      = cnt_q;
    eoc_n      = eoc_q;
    load_o     = 1'b0;
    load_val_o = decided;
    if (go_rise_i) begin
      state_n = ST_ARMED;
      sar_n   = '0;
      eoc_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_ARMED: begin
          if (go_fall_i) begin
            state_n = ST_CONV;
            sar_n   = MSB_ONE;
            idx_n   = IDX_TOP;
            cnt_n   = '0;
          end
        end
        ST_CONV: begin
          if (cnt_q == CNT_LAST) begin
            cnt_n = '0;
            if (idx_q == '0) begin
              load_o  = 1'b1;
              sar_n   = '0;
              state_n = ST_FIN;
            end else begin
              sar_n = decided | next_mask;
              idx_n = idx_q - 1'b1;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_FIN: begin
          eoc_n   = 1'b1;
          state_n = ST_IDLE;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      eoc_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      sar_q   <= sar_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      eoc_q   <= eoc_n;
    end
  end

  assign trial_o = sar_q;
  assign eoc_o   = eoc_q;
endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] data_q_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] dout_oe_o
);
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    data_n = data_q;
    if (load_i) data_n = load_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_n;
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_pad
    assign dout_o[g]    = data_q[g] & oe_i;
    assign dout_oe_o[g] = oe_i;
  end

  assign data_q_o = data_q;
endmodule

// File: rtl/sar_ctrl_top.sv
module sar_ctrl_top #(
  parameter int DATA_W       = 8,
  parameter int CH_W         = 3,
  parameter int CLKS_PER_BIT = 8,
  localparam int N_CH = 1 << CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [CH_W-1:0]   addr_i,
  input  logic              start_i,
  input  logic              cmp_i,
  input  logic              oe_i,
  output logic [N_CH-1:0]   ch_sel_o,
  output logic [DATA_W-1:0] trial_o,
  output logic              eoc_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] dout_oe_o
);
  logic              go_rise, go_fall;
  logic              load;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] data_q;

  sar_edge_det u_start_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (start_i),
    .rise_o (go_rise),
    .fall_o (go_fall)
  );

  sar_chan_latch #(.CH_W(CH_W)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (ale_i),
    .addr_i   (addr_i),
    .sel_o    (ch_sel_o)
  );

  sar_seq #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_rise_i  (go_rise),
    .go_fall_i  (go_fall),
    .cmp_i      (cmp_i),
    .trial_o    (trial_o),
    .load_o     (load),
    .load_val_o (load_val),
    .eoc_o      (eoc_o)
  );

  sar_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .oe_i       (oe_i),
    .data_q_o   (data_q),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int N_CH   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              oe_i,
  input logic [N_CH-1:0]   ch_sel_o,
  input logic [DATA_W-1:0] trial_o,
  input logic              eoc_o,
  input logic [DATA_W-1:0] dout_o,
  input logic [DATA_W-1:0] dout_oe_o,
  input logic [DATA_W-1:0] data_q
);
  logic start_prev;
  logic start_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_prev <= 1'b0;
    else        start_prev <= start_i;
  end

  assign start_up = start_i & ~start_prev;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_up |=> (trial_o == '0 && !eoc_o)); // R3

  AST_LOAD_THEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(data_q) && !start_up) |=> $rose(eoc_o)); // R6

  AST_DATA_HELD_LOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_o && $past(!eoc_o) && $past(trial_o) == '0 && trial_o == '0) |-> $stable(data_q)); // R7

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_sel_o) == 1); // R8

  AST_PAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |-> (dout_o == '0 && dout_oe_o == '0)); // R9

  AST_PAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_i |-> (dout_o == data_q)); // R9
endmodule

bind sar_ctrl_top sar_ctrl_chk #(.DATA_W(DATA_W), .N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .oe_i      (oe_i),
  .ch_sel_o  (ch_sel_o),
  .trial_o   (trial_o),
  .eoc_o     (eoc_o),
  .dout_o    (dout_o),
  .dout_oe_o (dout_oe_o),
  .data_q    (data_q)
);

// File: tb/sim_sar_ctrl_top.sv
module sim_sar_ctrl_top;
  logic       clk;
  logic       rst_n;
  logic       ale_i;
  logic [2:0] addr_i;
  logic       start_ext;
  logic       loop_en;
  logic       start_i;
  logic       cmp_i;
  logic       oe_i;
  logic [7:0] ch_sel_o;
  logic [7:0] trial_o;
  logic       eoc_o;
  logic [7:0] dout_o;
  logic [7:0] dout_oe_o;

  int n_cmp;
  int n_bad;
  int level [8];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign start_i = start_ext | (loop_en & eoc_o);

  sar_ctrl_top u0 (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .addr_i(addr_i),
    .start_i(start_i), .cmp_i(cmp_i), .oe_i(oe_i),
    .ch_sel_o(ch_sel_o), .trial_o(trial_o), .eoc_o(eoc_o),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o)
  );

  // analog model: selected level compared against the trial code
  int sel_level;
  always_comb begin
    sel_level = 0;
    for (int i = 0; i < 8; i++) if (ch_sel_o[i]) sel_level = level[i];
  end
  assign cmp_i = (sel_level >= int'(trial_o));

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_t;
  int m_ch;
  int m_data;
  bit m_eoc;
  bit m_ps;
  bit m_pa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = -1; m_ch = 0; m_data = 0; m_eoc = 0; m_ps = 0; m_pa = 0;
    end else begin
      if (ale_i && !m_pa) m_ch = int'(addr_i);
      if (start_i && !m_ps) begin
        m_t = -1; m_eoc = 0;
      end else if (!start_i && m_ps) begin
        m_t = 0;
      end else if (m_t >= 0) begin
        m_t = m_t + 1;
        if (m_t == 64) m_data = level[m_ch];
        if (m_t == 65) begin m_eoc = 1; m_t = -1; end
      end
      m_ps = start_i;
      m_pa = ale_i;
    end
  end

  function automatic int exp_trial();
    int idx;
    if (m_t < 0 || m_t > 63) return 0;
    idx = 7 - m_t / 8;
    return (level[m_ch] & ~((2 << idx) - 1) & 255) | (1 << idx);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 trial", int'(trial_o), exp_trial());
      check("R6 eoc", int'(eoc_o), int'(m_eoc));
      check("R8 sel", int'(ch_sel_o), 1 << m_ch);
      check("R9 dout", int'(dout_o), oe_i ? m_data : 0);
      check("R9 oe", int'(dout_oe_o), oe_i ? 255 : 0);
    end
  end

  int cyc;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic latch_ch(input int n);
    @(negedge clk); #1;
    addr_i = 3'(n); ale_i = 1'b1;
    @(negedge clk); #1;
    ale_i = 1'b0; addr_i = 3'(~n);
  endtask

  task automatic pulse_start(input int w);
    @(negedge clk); #1;
    start_ext = 1'b1;
    repeat (w) @(negedge clk);
    #1 start_ext = 1'b0;
  endtask

  task automatic run_conv(input int ch);
    latch_ch(ch);
    pulse_start(2);
    repeat (70) @(negedge clk);
    #1;
    check("R1 result", int'(dout_o), level[ch]);
    check("R6 flag", int'(eoc_o), 1);
  endtask

  int rises;
  int prev_data;

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0;
    level[0] = 8'h00; level[1] = 8'hFF; level[2] = 8'h5A; level[3] = 8'h80;
    level[4] = 8'h01; level[5] = 8'h7F; level[6] = 8'hC3; level[7] = 8'hA5;
    rst_n = 1'b0; ale_i = 1'b0; addr_i = 3'd0; start_ext = 1'b0;
    loop_en = 1'b0; oe_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R10 eoc", int'(eoc_o), 0);
    check("R10 trial", int'(trial_o), 0);
    check("R10 dout", int'(dout_o), 0);
    check("R10 sel", int'(ch_sel_o), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_conv(2);
    run_conv(1);
    run_conv(0);
    run_conv(4);

    // R8: address changes without the strobe are ignored
    latch_ch(6);
    repeat (3) @(negedge clk);
    #1 check("R8 no strobe", int'(ch_sel_o), 8'h40);

    // R4, R2 on channel 7
    latch_ch(7);
    pulse_start(2);
    @(negedge clk); #1;
    check("R4 first trial", int'(trial_o), 8'h80);
    repeat (8) @(negedge clk);
    #1 check("R2 second trial", int'(trial_o), 8'hC0);
    repeat (70) @(negedge clk);
    #1 check("R1 result ch7", int'(dout_o), 8'hA5);

    // R5, R3, R7: abort mid conversion
    latch_ch(3);
    prev_data = int'(dout_o);
    pulse_start(2);
    repeat (20) @(negedge clk);
    #1 check("R7 held", int'(dout_o), prev_data);
    @(negedge clk); #1;
    start_ext = 1'b1;
    @(negedge clk); #1;
    check("R3 trial cleared", int'(trial_o), 0);
    check("R3 eoc low", int'(eoc_o), 0);
    start_ext = 1'b0;
    repeat (40) @(negedge clk);
    #1 check("R7 held after abort", int'(dout_o), prev_data);
    repeat (30) @(negedge clk);
    #1 check("R5 restarted result", int'(dout_o), 8'h80);

    // R9: pads disabled
    oe_i = 1'b0;
    @(negedge clk); #1;
    check("R9 gated", int'(dout_o), 0);
    check("R9 enables off", int'(dout_oe_o), 0);
    oe_i = 1'b1;

    // R11: continuous conversion
    latch_ch(5);
    loop_en = 1'b1;
    pulse_start(2);
    rises = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (eoc_o && u_prev_eoc == 1'b0) rises++;
      u_prev_eoc = eoc_o;
    end
    check("R11 repeats", (rises >= 5) ? 1 : 0, 1);
    #1 check("R11 value", int'(dout_o), 8'h7F);
    loop_en = 1'b0;
    repeat (80) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic u_prev_eoc = 1'b0;
endmodule